// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address-Frame Sleep

This block receives asynchronous serial frames on a multidrop line. Each frame carries eight data bits and one extra bit that marks it as either an address frame or a data frame. The block deserializes each frame into an internal shift register. It then decides whether to hand the frame to software through a receive data register. A 16x oversampling enable comes from outside the block, because baud generation is not part of it.

The receiver has a sleep control. While sleep is set, only address frames reach the data register, raise the ready flag, request an interrupt and request DMA. Data frames are still assembled, but they are dropped. Address matching is left to software: it reads each address and clears sleep when the station is being addressed. A wake flag records whether the buffered byte is an address or data, so that software can tell when a new address arrives while it is awake. Framing errors are recorded even for frames that sleep throws away.

A small register port gives software its access. Register 0 is the received byte, and reading it clears ready. Register 1 is the control register. Register 2 is the status register, whose error bits are cleared by writing ones to them.

Top module: `mpuart_rx`

## Requirements
- R1: A frame is one low start bit, 8 data bits sent LSB first, one address bit (1 = address frame) and one stop bit. Each bit lasts 16 `os_tick` pulses. Its value is the majority of the samples at tick counts 7, 8 and 9 of the bit, so a single corrupted sample does not change the received byte.
- R2: With sleep clear (control bit 0 = 0), every completed frame is moved into the data register (address 0) and sets ready (status bit 0).
- R3: With sleep set, a completed data frame leaves the data register unchanged. It does not set ready, does not raise `irq` and does not pulse `dma_req`.
- R4: With sleep set, a completed address frame is moved into the data register and sets ready.
- R5: The wake flag (status bit 1) is loaded on every transfer into the data register: 1 for an address frame, 0 for a data frame. Without a transfer it holds its value.
- R6: `irq` is high exactly while ready is set and the receive interrupt enable (control bit 1) is 1. With the enable at 0, ready can still be polled in the status register.
- R7: When DMA is enabled (control bit 2), `dma_req` is high for exactly one clock after each transfer into the data register. With DMA disabled it stays low.
- R8: A stop bit whose vote is low sets the framing error flag (status bit 2). This also happens for data frames discarded during sleep.
- R9: A transfer that happens while ready is still set sets the overrun flag (status bit 3).
- R10: Reading address 0 clears ready. Writing address 2 with bit 2 and/or bit 3 set clears the matching error flag.
- R11: A falling edge whose vote at the middle of the start bit is high is rejected as noise. It produces no frame, and a later valid frame is received correctly.
- R12: The control register at address 1 reads back its written value in bits 2:0. The block does no address comparison of its own: only the sleep bit decides whether data frames pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-clock enable at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read clears ready) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Receive interrupt request |
| dma_req | output | 1 | One-clock DMA request per transfer |

## Verification
The assertions check the following on every cycle:
- a discarded data frame in sleep never changes the data register, ready or the DMA request;
- an address frame always sets ready;
- the wake flag follows the type of each transferred frame;
- framing error and overrun set when their conditions occur;
- a data read clears ready;
- DMA pulses never last two cycles.

Only the bench's scenarios can show the line-level behaviour. This covers correct LSB-first assembly, tolerance of a single bad sample, rejection of a noisy start edge, and the software sequence of sleeping, catching an address, waking and polling.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

    localparam int DATA_W = 8;
    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] REG_DATA = 2'd0;
    localparam logic [REG_AW-1:0] REG_CTRL = 2'd1;
    localparam logic [REG_AW-1:0] REG_STAT = 2'd2;

    localparam int ST_READY = 0;
    localparam int ST_WAKE  = 1;
    localparam int ST_FERR  = 2;
    localparam int ST_OVR   = 3;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              is_addr;
        logic              ferr;
    } frame_t;

    typedef struct packed {
        logic dma_en;
        logic rx_ie;
        logic sleep;
    } ctrl_t;

    typedef enum logic {
        RX_IDLE,
        RX_BITS
    } rx_state_e;

    function automatic logic majority3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
    endfunction

endpackage

// File: rtl/mpuart_sync.sv
module mpuart_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mpuart_deframer.sv
module mpuart_deframer
    import mpuart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   os_tick,
    input  logic   rxd_s,
    output logic   frm_done,
    output frame_t frm
);
    localparam int CNT_W      = $clog2(OSR);
    localparam int MID        = OSR / 2;
    localparam int BITS_TOTAL = DATA_W + 3;
    localparam int IDX_W      = $clog2(BITS_TOTAL + 1);
    localparam logic [CNT_W-1:0] S0   = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] S1   = CNT_W'(MID);
    localparam logic [CNT_W-1:0] S2   = CNT_W'(MID + 1);
    localparam logic [CNT_W-1:0] VOTE = CNT_W'(MID + 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_ADDR = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] IDX_LDAT = IDX_W'(DATA_W);

    rx_state_e         state;
    logic [CNT_W-1:0]  os_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [2:0]        samp;
    logic [DATA_W-1:0] shreg;
    logic              addr_bit;
    logic              vote;

    assign vote = majority3(samp);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            os_cnt   <= '0;
            bit_idx  <= '0;
            samp     <= '1;
            shreg    <= '0;
            addr_bit <= 1'b0;
            frm_done <= 1'b0;
            frm      <= '0;
        end else begin
            frm_done <= 1'b0;
            if (os_tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxd_s) begin
                            state   <= RX_BITS;
                            os_cnt  <= CNT_W'(1);
                            bit_idx <= '0;
                        end
                    end
                    RX_BITS: begin
                        if (os_cnt == LAST) begin
                            os_cnt  <= '0;
                            bit_idx <= bit_idx + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                        if (os_cnt == S0) samp[0] <= rxd_s;
                        if (os_cnt == S1) samp[1] <= rxd_s;
                        if (os_cnt == S2) samp[2] <= rxd_s;
                        if (os_cnt == VOTE) begin
                            if (bit_idx == '0) begin
                                if (vote) state <= RX_IDLE;
                            end else if (bit_idx <= IDX_LDAT) begin
                                shreg <= {vote, shreg[DATA_W-1:1]};
                            end else if (bit_idx == IDX_ADDR) begin
                                addr_bit <= vote;
                            end else begin
                                frm_done    <= 1'b1;
                                frm.data    <= shreg;
                                frm.is_addr <= addr_bit;
                                frm.ferr    <= ~vote;
                                state       <= RX_IDLE;
                            end
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpuart_regs.sv
module mpuart_regs
    import mpuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_done,
    input  frame_t            frm,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              dma_req,
    output logic              ready_q,
    output logic              wake_q,
    output logic              ferr_q,
    output logic              ovr_q,
    output logic [DATA_W-1:0] data_q,
    output ctrl_t             ctrl_q
);
    logic xfer;
    logic rd_data;
    logic wr_stat;

    assign xfer    = frm_done & (frm.is_addr | ~ctrl_q.sleep);
    assign rd_data = reg_rd & (reg_addr == REG_DATA);
    assign wr_stat = reg_wr & (reg_addr == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            wake_q  <= 1'b0;
            ferr_q  <= 1'b0;
            ovr_q   <= 1'b0;
            data_q  <= '0;
            ctrl_q  <= '0;
            dma_req <= 1'b0;
        end else begin
            dma_req <= xfer & ctrl_q.dma_en;
            if (reg_wr && reg_addr == REG_CTRL)
                ctrl_q <= ctrl_t'(reg_wdata[2:0]);
            if (xfer) begin
                data_q  <= frm.data;
                wake_q  <= frm.is_addr;
                ready_q <= 1'b1;
            end else if (rd_data) begin
                ready_q <= 1'b0;
            end
            if (frm_done && frm.ferr)          ferr_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_FERR]) ferr_q <= 1'b0;
            if (xfer && ready_q && !rd_data)   ovr_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_OVR])  ovr_q <= 1'b0;
        end
    end

    assign irq = ready_q & ctrl_q.rx_ie;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_DATA: reg_rdata = data_q;
            REG_CTRL: reg_rdata[2:0] = ctrl_q;
            REG_STAT: begin
                reg_rdata[ST_READY] = ready_q;
                reg_rdata[ST_WAKE]  = wake_q;
                reg_rdata[ST_FERR]  = ferr_q;
                reg_rdata[ST_OVR]   = ovr_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              dma_req
);
    logic              rxd_s;
    logic              frm_done;
    frame_t            frm;
    logic              ready_q, wake_q, ferr_q, ovr_q;
    logic [DATA_W-1:0] data_q;
    ctrl_t             ctrl_q;

    mpuart_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .din(rxd), .dout(rxd_s)
    );

    mpuart_deframer #(.OSR(OSR)) deframer_i (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd_s(rxd_s),
        .frm_done(frm_done), .frm(frm)
    );

    mpuart_regs regs_i (
        .clk(clk), .rst(rst), .frm_done(frm_done), .frm(frm),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .dma_req(dma_req), .ready_q(ready_q), .wake_q(wake_q),
        .ferr_q(ferr_q), .ovr_q(ovr_q), .data_q(data_q), .ctrl_q(ctrl_q)
    );
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk
    import mpuart_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_rd,
    input logic              dma_req,
    input logic              frm_done,
    input frame_t            frm,
    input logic              ready_q,
    input logic              wake_q,
    input logic              ferr_q,
    input logic              ovr_q,
    input logic [DATA_W-1:0] data_q,
    input ctrl_t             ctrl_q
);
    logic will_xfer;
    assign will_xfer = frm_done && (frm.is_addr || !ctrl_q.sleep);

    // R3
    a_r3_sleep_drops_data: assert property (@(posedge clk) disable iff (rst)
        (frm_done && !frm.is_addr && ctrl_q.sleep)
        |=> ($stable(data_q) && !dma_req && !$rose(ready_q)));

    // R4
    a_r4_addr_sets_ready: assert property (@(posedge clk) disable iff (rst)
        (frm_done && frm.is_addr) |=> ready_q);

    // R5
    a_r5_wake_tracks_type: assert property (@(posedge clk) disable iff (rst)
        will_xfer |=> (wake_q == $past(frm.is_addr)));

    // R7
    a_r7_dma_one_cycle: assert property (@(posedge clk) disable iff (rst)
        dma_req |=> !dma_req);

    // R8
    a_r8_ferr_sets: assert property (@(posedge clk) disable iff (rst)
        (frm_done && frm.ferr) |=> ferr_q);

    // R9
    a_r9_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (will_xfer && ready_q && !(reg_rd && reg_addr == REG_DATA)) |=> ovr_q);

    // R10
    a_r10_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == REG_DATA && !frm_done) |=> !ready_q);
endmodule

bind mpuart_rx mpuart_rx_chk chk_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .dma_req(dma_req), .frm_done(frm_done), .frm(frm), .ready_q(ready_q),
    .wake_q(wake_q), .ferr_q(ferr_q), .ovr_q(ovr_q), .data_q(data_q),
    .ctrl_q(ctrl_q)
);

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       dma_req;

    int n_checks = 0;
    int n_fails  = 0;
    int dma_cnt  = 0;
    bit finished = 1'b0;

    mpuart_rx dut_i (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .dma_req(dma_req)
    );

    initial forever #2 clk = ~clk;

    // oversampling enable every second clock: one bit = 32 clocks
    initial forever begin
        @(negedge clk);
        os_tick = ~os_tick;
    end

    initial forever begin
        @(posedge clk);
        #1;
        if (dma_req) dma_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // glitch_bit >= 0 inverts two clocks (one sample) in the middle of that bit
    task automatic send_frame(input logic [7:0] d, input logic a,
                              input logic stop, input int glitch_bit);
        logic [10:0] bits;
        bits = {stop, a, d, 1'b0};
        for (int b = 0; b < 11; b++) begin
            for (int j = 0; j < 32; j++) begin
                @(negedge clk);
                rxd = (b == glitch_bit && (j == 16 || j == 17)) ? ~bits[b] : bits[b];
            end
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_read(2'd2, v); chk("R2 reset status", v, 8'h00);
        reg_read(2'd1, v); chk("R12 reset ctrl", v, 8'h00);
        reg_read(2'd0, v); chk("R2 reset data", v, 8'h00);
        chk("R6 reset irq", irq, 0);
    endtask

    task automatic t_awake_data();
        logic [7:0] v; int d0;
        reg_write(2'd1, 8'h06);
        reg_read(2'd1, v); chk("R12 ctrl readback", v, 8'h06);
        d0 = dma_cnt;
        send_frame(8'hA5, 1'b0, 1'b1, -1);
        reg_read(2'd2, v); chk("R2 R5 status after awake data", v, 8'h01);
        chk("R6 irq raised", irq, 1);
        chk("R7 one dma pulse", dma_cnt - d0, 1);
        reg_read(2'd0, v); chk("R1 R2 data LSB first", v, 8'hA5);
        reg_read(2'd2, v); chk("R10 ready cleared by read", v, 8'h00);
        chk("R6 irq dropped", irq, 0);
    endtask

    task automatic t_majority();
        logic [7:0] v;
        send_frame(8'h5A, 1'b0, 1'b1, 4);
        reg_read(2'd0, v); chk("R1 single bad sample outvoted", v, 8'h5A);
    endtask

    task automatic t_sleep_data();
        logic [7:0] v; int d0;
        reg_write(2'd1, 8'h07);
        d0 = dma_cnt;
        send_frame(8'h3C, 1'b0, 1'b1, -1);
        reg_read(2'd2, v); chk("R3 sleep data no ready", v, 8'h00);
        chk("R3 sleep data no irq", irq, 0);
        chk("R3 sleep data no dma", dma_cnt - d0, 0);
        reg_read(2'd0, v); chk("R3 data register unchanged", v, 8'h5A);
    endtask

    task automatic t_sleep_addr();
        logic [7:0] v; int d0;
        d0 = dma_cnt;
        send_frame(8'h42, 1'b1, 1'b1, -1);
        reg_read(2'd2, v); chk("R4 R5 addr in sleep: ready and wake", v, 8'h03);
        chk("R6 irq on address", irq, 1);
        chk("R7 dma on address", dma_cnt - d0, 1);
        reg_read(2'd0, v); chk("R4 address byte", v, 8'h42);
    endtask

    task automatic t_wake_data();
        logic [7:0] v;
        reg_write(2'd1, 8'h06);
        send_frame(8'h77, 1'b0, 1'b1, -1);
        reg_read(2'd2, v); chk("R5 wake cleared by data", v, 8'h01);
        reg_read(2'd0, v); chk("R12 data passes after sleep cleared", v, 8'h77);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send_frame(8'h11, 1'b0, 1'b1, -1);
        send_frame(8'h22, 1'b0, 1'b1, -1);
        reg_read(2'd2, v); chk("R9 overrun flagged", v, 8'h09);
        reg_read(2'd0, v); chk("R9 newest byte kept", v, 8'h22);
        reg_write(2'd2, 8'h08);
        reg_read(2'd2, v); chk("R10 overrun cleared by W1C", v, 8'h00);
    endtask

    task automatic t_framing_sleep();
        logic [7:0] v;
        reg_write(2'd1, 8'h07);
        send_frame(8'h99, 1'b0, 1'b0, -1);
        reg_read(2'd2, v); chk("R8 framing error while asleep", v, 8'h04);
        chk("R3 no irq on bad data frame", irq, 0);
        reg_write(2'd2, 8'h04);
        reg_read(2'd2, v); chk("R10 framing error cleared", v, 8'h00);
    endtask

    task automatic t_noise();
        logic [7:0] v;
        reg_write(2'd1, 8'h06);
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (80) @(negedge clk);
        reg_read(2'd2, v); chk("R11 noise start ignored", v, 8'h00);
        send_frame(8'hC3, 1'b0, 1'b1, -1);
        reg_read(2'd0, v); chk("R11 next frame intact", v, 8'hC3);
    endtask

    task automatic t_poll();
        logic [7:0] v; int d0;
        reg_write(2'd1, 8'h01);
        d0 = dma_cnt;
        send_frame(8'h5E, 1'b1, 1'b1, -1);
        chk("R6 no irq when disabled", irq, 0);
        chk("R7 no dma when disabled", dma_cnt - d0, 0);
        reg_read(2'd2, v); chk("R6 ready pollable", v, 8'h03);
        reg_read(2'd0, v); chk("R4 polled address", v, 8'h5E);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_awake_data();
        t_majority();
        t_sleep_data();
        t_sleep_addr();
        t_wake_data();
        t_overrun();
        t_framing_sleep();
        t_noise();
        t_poll();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule